// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check Phase

This block is a small processor with a 16-bit word and one data register, the accumulator. It works through a multicycle sequence on every instruction: a fetch, an execute phase, and then an interrupt check. A single word-addressed memory port carries all traffic. The port has a 12-bit address, separate read and write data buses, and one-cycle read and write strobes. Read data arrives on the cycle after the read strobe.

Each instruction word holds an opcode in its upper four bits and a memory word address in its lower twelve bits. The instruction set covers load, add, store, jump, halt and return-from-interrupt. One level-sensitive request line feeds the interrupt check. When a request is taken, the block saves the program counter in a private register, jumps to a fixed handler address and masks further requests until the handler returns. A request that comes in while requests are masked is held, not dropped.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word carries its opcode in bits [15:12] and a word address in bits [11:0]. Opcode 0x1 loads the accumulator from the addressed word.
- R2: Opcode 0x5 adds the addressed word to the accumulator and keeps the 16-bit sum in the accumulator.
- R3: Opcode 0x2 writes the accumulator to the addressed word with one write-strobe cycle, with the value on the write data bus.
- R4: A synchronous reset clears the program counter, the instruction register and the accumulator, enables interrupts and keeps both strobes and the halted output low. The first fetch reads address 0x000. Each fetch advances the program counter by one.
- R5: Opcode 0x8 loads the program counter with its address field, so the word that follows the jump is never executed.
- R6: Opcode 0x0 raises the halted output. The output stays high until reset, and no strobe is issued while it is high.
- R7: Opcodes with no assigned meaning, for example 0x7, change neither the accumulator nor memory.
- R8: After every execute phase, a pending request with interrupts enabled saves the program counter, loads 0xF00 into it and disables interrupts. With no request pending, the next fetch follows at once.
- R9: A request seen while interrupts are disabled stays pending. It is taken at the first check after interrupts are enabled again.
- R10: Opcode 0xF restores the saved program counter and enables interrupts.
- R11: Memory read data is taken one cycle after the read strobe. A strobe lasts one cycle, and the read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| irq | input | 1 | Level-sensitive interrupt request |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The fetch takes three cycles. Load and add take three more, and store, jump, return and no-op take one. Every instruction then takes one cycle for the interrupt check, and a store's write strobe appears in that cycle. The bench models a memory that returns data one cycle after the strobe. It compares every write strobe, in order, against a queue of expected address and data pairs, so the check fires on the cycle the write appears, whatever the count of cycles before it. The bench raises the interrupt request on the cycle a chosen write is seen. The request is therefore latched too late for that instruction's own check and is taken at the next instruction's check, which fixes the saved program counter. The request is held high into the handler, and that tests that it stays pending while interrupts are masked.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [2:0] {
        OPC_HALT,
        OPC_LOAD,
        OPC_STORE,
        OPC_ADD,
        OPC_JUMP,
        OPC_RET,
        OPC_NOP
    } op_class_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_FREQ,
        ST_FWAIT,
        ST_EXEC,
        ST_OREQ,
        ST_OWAIT,
        ST_ICHK,
        ST_HALT
    } cpu_state_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int OPW = 4
) (
    input  logic [OPW-1:0] opcode,
    output op_class_e      op_class
);

    always_comb begin
        case (opcode)
            4'h0:    op_class = OPC_HALT;   // R6
            4'h1:    op_class = OPC_LOAD;   // R1
            4'h2:    op_class = OPC_STORE;  // R3
            4'h5:    op_class = OPC_ADD;    // R2
            4'h8:    op_class = OPC_JUMP;   // R5
            4'hF:    op_class = OPC_RET;    // R10
            default: op_class = OPC_NOP;    // R7
        endcase
    end

endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic check,
    input  logic reenable,
    output logic take,
    output logic enabled
);

    typedef struct packed {
        logic pend;
        logic ien;
    } irq_reg_t;

    irq_reg_t r_q, r_d;

    assign take    = check && r_q.pend && r_q.ien;
    assign enabled = r_q.ien;

    always_comb begin
        r_d      = r_q;
        r_d.pend = (r_q.pend && !take) || irq;
        if (take)
            r_d.ien = 1'b0;
        else if (reenable)
            r_d.ien = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.pend <= 1'b0;
            r_q.ien  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (rst)
        take |=> !enabled); // R8
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (r_q.pend && !take) |=> r_q.pend); // R9
    AST_REENABLE: assert property (@(posedge clk) disable iff (rst)
        (reenable && !take) |=> enabled); // R10

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          DW       = 16,
    parameter logic [11:0] VEC_ADDR = 12'hF00
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic          irq,
    output logic          halted
);

    localparam int OPW = DW - AW;

    typedef struct packed {
        cpu_state_e    state;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] acc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [AW-1:0] save;
        logic          rd;
        logic          wr;
        logic          halt;
    } core_reg_t;

    core_reg_t     r_q, r_d;
    op_class_e     op;
    logic          take;
    logic          ien;
    logic [AW-1:0] ir_addr;

    assign ir_addr = r_q.ir[AW-1:0];

    acc_cpu_decode #(.OPW(OPW)) u_decode (
        .opcode   (r_q.ir[DW-1:AW]),
        .op_class (op)
    );

    acc_cpu_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .irq      (irq),
        .check    (r_q.state == ST_ICHK),
        .reenable ((r_q.state == ST_EXEC) && (op == OPC_RET)),
        .take     (take),
        .enabled  (ien)
    );

    always_comb begin
        r_d    = r_q;
        r_d.rd = 1'b0;
        r_d.wr = 1'b0;
        case (r_q.state)
            ST_FETCH: begin
                r_d.mar   = r_q.pc;                  // R4
                r_d.rd    = 1'b1;
                r_d.state = ST_FREQ;
            end
            ST_FREQ:  r_d.state = ST_FWAIT;          // R11
            ST_FWAIT: begin
                r_d.ir    = mem_rdata;
                r_d.pc    = r_q.pc + 1'b1;           // R4
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.state = ST_ICHK;
                case (op)
                    OPC_LOAD, OPC_ADD: begin
                        r_d.mar   = ir_addr;
                        r_d.rd    = 1'b1;
                        r_d.state = ST_OREQ;
                    end
                    OPC_STORE: begin
                        r_d.mar = ir_addr;
                        r_d.mbr = r_q.acc;           // R3
                        r_d.wr  = 1'b1;
                    end
                    OPC_JUMP: r_d.pc = ir_addr;      // R5
                    OPC_RET:  r_d.pc = r_q.save;     // R10
                    OPC_HALT: begin
                        r_d.halt  = 1'b1;            // R6
                        r_d.state = ST_HALT;
                    end
                    default: ;                       // R7
                endcase
            end
            ST_OREQ:  r_d.state = ST_OWAIT;
            ST_OWAIT: begin
                r_d.mbr = mem_rdata;
                if (op == OPC_LOAD)
                    r_d.acc = mem_rdata;             // R1
                else
                    r_d.acc = r_q.acc + mem_rdata;   // R2
                r_d.state = ST_ICHK;
            end
            ST_ICHK: begin
                if (take) begin
                    r_d.save = r_q.pc;               // R8
                    r_d.pc   = VEC_ADDR[AW-1:0];
                end
                r_d.state = ST_FETCH;
            end
            default: r_d.state = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_FETCH;
            r_q.pc    <= '0;
            r_q.ir    <= '0;
            r_q.acc   <= '0;
            r_q.mar   <= '0;
            r_q.mbr   <= '0;
            r_q.save  <= '0;
            r_q.rd    <= 1'b0;
            r_q.wr    <= 1'b0;
            r_q.halt  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_rd    = r_q.rd;
    assign mem_wr    = r_q.wr;
    assign mem_wdata = r_q.mbr;
    assign halted    = r_q.halt;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd); // R11
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr)); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R6
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_FWAIT) |=> (r_q.pc == $past(r_q.pc) + 1'b1)); // R4
    AST_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_ICHK && take) |=> (r_q.pc == VEC_ADDR[AW-1:0] && !ien)); // R8

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic        irq = 1'b0;
    logic        halted;

    int n_cmp = 0;
    int n_bad = 0;
    int vec_reads = 0;
    int overlap = 0;
    bit seen_110 = 1'b0;
    bit first_fetch_seen = 1'b0;

    typedef struct {
        logic [11:0] addr;
        logic [15:0] data;
        string       tag;
    } wr_item_t;

    wr_item_t exp_q[$];
    logic [15:0] mem [4096];

    always #2.5 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .irq       (irq),
        .halted    (halted)
    );

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_wr(input logic [11:0] a, input logic [15:0] d, input string tag);
        wr_item_t it;
        it.addr = a;
        it.data = d;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compares writes, drives the request from observed progress
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd && mem_wr) overlap++;
            if (mem_rd && !first_fetch_seen) begin
                first_fetch_seen = 1'b1;
                check(mem_addr == 12'h000, "R4 first fetch address", mem_addr, 12'h000);
            end
            if (mem_rd && mem_addr == 12'hF00) vec_reads++;
            if (mem_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected write", mem_addr, 0);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check(mem_addr == it.addr, {it.tag, " addr"}, mem_addr, it.addr);
                    check(mem_wdata == it.data, {it.tag, " data"}, mem_wdata, it.data);
                end
                if (mem_addr == 12'h105) irq = 1'b1;
                if (mem_addr == 12'h110 && !seen_110) begin
                    seen_110 = 1'b1;
                    irq = 1'b0;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        mem[12'h000] = 16'h1100;  // load 0x100
        mem[12'h001] = 16'h5101;  // add 0x101
        mem[12'h002] = 16'h2102;  // store 0x102
        mem[12'h003] = 16'h8010;  // jump 0x010
        mem[12'h004] = 16'h2103;  // skipped
        mem[12'h010] = 16'h5101;  // add
        mem[12'h011] = 16'h2104;  // store
        mem[12'h012] = 16'h7123;  // no-op
        mem[12'h013] = 16'h2105;  // store
        mem[12'h014] = 16'h1106;  // load 0x00AA
        mem[12'h015] = 16'h2108;  // store
        mem[12'h016] = 16'h0000;  // halt
        mem[12'hF00] = 16'h2110;  // handler: store
        mem[12'hF01] = 16'h1111;  // load 0x0BEE
        mem[12'hF02] = 16'hF000;  // return
        mem[12'h100] = 16'h0005;
        mem[12'h101] = 16'h0007;
        mem[12'h106] = 16'h00AA;
        mem[12'h111] = 16'h0BEE;

        push_wr(12'h102, 16'h000C, "R1 R2 R3 load-add-store");
        push_wr(12'h104, 16'h0013, "R5 jump target executed");
        push_wr(12'h105, 16'h0013, "R7 no-op keeps accumulator");
        push_wr(12'h110, 16'h00AA, "R8 handler entry");
        push_wr(12'h110, 16'h0BEE, "R9 pending request retaken");
        push_wr(12'h108, 16'h0BEE, "R10 return to saved PC");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_rd == 1'b0, "R4 reset read strobe", mem_rd, 0);
        check(mem_wr == 1'b0, "R4 reset write strobe", mem_wr, 0);
        check(halted == 1'b0, "R4 reset halted", halted, 0);
        rst = 1'b0;

        wait (halted === 1'b1);
        @(negedge clk);
        check(halted == 1'b1, "R6 halted raised", halted, 1);
        repeat (10) begin
            @(negedge clk);
            if (mem_rd || mem_wr || !halted)
                check(1'b0, "R6 quiet after halt", {mem_rd, mem_wr, halted}, 3'b001);
        end
        check(exp_q.size() == 0, "R5 R9 writes outstanding", exp_q.size(), 0);
        check(vec_reads == 2, "R8 R9 handler entries", vec_reads, 2);
        check(overlap == 0, "R11 strobe overlap", overlap, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule